// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates five interrupt sources for a small processor core. The sources are two external pins (active low), two timer overflow flags and one serial flag that is the OR of the transmit and receive flags. Each source has its own enable bit, and a global enable gates all of them. A priority bit puts each source in the high or the low level. The block presents one request at a time, with the fixed vector address of the winning source and the level that source was granted.

Each external pin is either level-sensitive or falling-edge-sensitive. In edge mode a falling edge is stored in a flag. The flag holds the request until the core acknowledges that vector. The core acknowledges a presented request with an `ack_i` pulse, which marks that level as in service. A `reti_i` pulse ends the handler at the deepest active level. A high-level request may interrupt a low-level handler. Nothing interrupts a high-level handler. A low-level request waits while any handler is running. A request that is masked stays pending and is presented once it is unmasked.

Top module: `irq_ctrl_2lvl`

## Requirements
- R1: After reset `irq_o` is 0, `vector_o` is 0x00 and `in_svc_o` is 0. While `irq_o` is 0, `vector_o` is 0x00.
- R2: A source is a candidate only if its `src_en_i` bit and `glb_en_i` are both 1. The `src_en_i` bit order is ext0 = bit 0, tmr0 = bit 1, ext1 = bit 2, tmr1 = bit 3, serial = bit 4. A masked request is not lost: an edge flag stays set and is presented once the source is enabled.
- R3: The vector is 0x03 + 8 × index, where the index is ext0 = 0, tmr0 = 1, ext1 = 2, tmr1 = 3, serial = 4. The resulting vectors are 0x03, 0x0B, 0x13, 0x1B and 0x23.
- R4: A source whose `prio_i` bit is 1 (same bit order as R2) is high level. Any eligible high-level request wins over every low-level request.
- R5: Among eligible requests of the same level, the lowest index wins.
- R6: With `ext_edge_i[j]` = 0, external j requests while `ext_ni[j]` is low. `irq_o` reflects a pin change after one rising clock edge.
- R7: With `ext_edge_i[j]` = 1, a falling edge on `ext_ni[j]` sets a flag. The flag keeps the request after the pin returns high, and `irq_o` rises at the second rising edge after the fall. Acknowledging that vector clears the flag. A level-mode request is never cleared by the block.
- R8: An `ack_i` pulse while `irq_o` is 1 drops `irq_o` at the next edge. The same edge sets `in_svc_o[1]` for a high-level grant or `in_svc_o[0]` for a low-level grant.
- R9: While `in_svc_o[1]` is 1, no request is presented. While only `in_svc_o[0]` is 1, only high-level requests are presented.
- R10: `reti_i` clears `in_svc_o[1]` if it is set, otherwise it clears `in_svc_o[0]`. Requests held back by nesting are then presented again.
- R11: `irq_lvl_o` is 1 when the presented request is high level and 0 when it is low level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_ni | input | 2 | External interrupt pins, active low |
| ext_edge_i | input | 2 | Per pin: 1 = falling-edge mode, 0 = level mode |
| tmr_ovf_i | input | 2 | Timer 0/1 overflow flags |
| ser_flag_i | input | 1 | Serial transmit OR receive flag |
| glb_en_i | input | 1 | Global interrupt enable |
| src_en_i | input | 5 | Per-source enables (order in R2) |
| prio_i | input | 5 | Per-source level, 1 = high |
| ack_i | input | 1 | Core takes the presented vector |
| reti_i | input | 1 | Return from the current handler |
| irq_o | output | 1 | Request to the core |
| vector_o | output | 8 | Vector address of the presented source |
| irq_lvl_o | output | 1 | Level of the presented request |
| in_svc_o | output | 2 | In-service levels: bit 1 high, bit 0 low |

## Verification
A level change on a timer, serial or level-mode pin shows on `irq_o`, `vector_o` and `irq_lvl_o` after exactly one rising edge. An edge-mode fall takes two rising edges, because the flag is registered first. `ack_i` and `reti_i` act on `in_svc_o` at the next edge. Once `in_svc_o` has changed, the nesting decision shows on `irq_o` one edge after that. The bench drives every input on the falling clock edge and steps one rising edge per check. It samples on the following falling edge, and it checks the edge-mode case at both the first and the second edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } lvl_e;
endpackage

// File: rtl/irq_ext_src.sv
module irq_ext_src (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  input  logic edge_mode_i,
  input  logic clr_i,
  output logic req_o
);
  logic pin_q, flag_q, fall;

  assign fall = pin_q & ~pin_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q  <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      pin_q  <= pin_ni;
      // a new fall wins over a clear in the same cycle
      flag_q <= edge_mode_i & (fall | (flag_q & ~clr_i));
    end
  end

  assign req_o = edge_mode_i ? flag_q : ~pin_ni;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N_SRC = 5,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic             gie_i,
  input  logic [N_SRC-1:0] prio_i,
  input  logic [1:0]       in_svc_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] src_o,
  output lvl_e             lvl_o
);
  logic [N_SRC-1:0] elig, hi, lo;
  logic [IDX_W-1:0] hi_idx, lo_idx;

  assign elig = pend_i & en_i & {N_SRC{gie_i}};
  assign hi   = elig & prio_i;
  assign lo   = elig & ~prio_i;

  always_comb begin
    hi_idx = '0;
    lo_idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (hi[i]) hi_idx = IDX_W'(i);
      if (lo[i]) lo_idx = IDX_W'(i);
    end
  end

  always_comb begin
    valid_o = 1'b0;
    src_o   = '0;
    lvl_o   = LVL_LO;
    if (!in_svc_i[1] && |hi) begin
      valid_o = 1'b1;
      src_o   = hi_idx;
      lvl_o   = LVL_HI;
    end else if (in_svc_i == 2'b00 && |lo) begin
      valid_o = 1'b1;
      src_o   = lo_idx;
    end
  end
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track
  import irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       take_i,
  input  lvl_e       take_lvl_i,
  input  logic       reti_i,
  output logic [1:0] in_svc_o
);
  logic [1:0] svc_q, svc_d;

  always_comb begin
    svc_d = svc_q;
    if (reti_i) begin
      if (svc_q[1]) svc_d[1] = 1'b0;
      else          svc_d[0] = 1'b0;
    end
    if (take_i) svc_d[take_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) svc_q <= 2'b00;
    else         svc_q <= svc_d;
  end

  assign in_svc_o = svc_q;
endmodule

// File: rtl/irq_ctrl_2lvl.sv
module irq_ctrl_2lvl
  import irq_pkg::*;
#(
  parameter int N_PAIR     = 2,
  parameter int VEC_W      = 8,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  localparam int N_SRC     = 2 * N_PAIR + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PAIR-1:0] ext_ni,
  input  logic [N_PAIR-1:0] ext_edge_i,
  input  logic [N_PAIR-1:0] tmr_ovf_i,
  input  logic              ser_flag_i,
  input  logic              glb_en_i,
  input  logic [N_SRC-1:0]  src_en_i,
  input  logic [N_SRC-1:0]  prio_i,
  input  logic              ack_i,
  input  logic              reti_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vector_o,
  output logic              irq_lvl_o,
  output logic [1:0]        in_svc_o
);
  localparam int IDX_W = $clog2(N_SRC);

  logic [N_SRC-1:0] pend;
  logic             win_valid, irq_q, take;
  logic [IDX_W-1:0] win_src, src_q;
  lvl_e             win_lvl, lvl_q;

  assign take = ack_i & irq_q;

  // sources interleave: ext j at 2j, timer j at 2j+1, serial last
  for (genvar j = 0; j < N_PAIR; j++) begin : g_pair
    irq_ext_src u_ext (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .pin_ni      (ext_ni[j]),
      .edge_mode_i (ext_edge_i[j]),
      .clr_i       (take && src_q == IDX_W'(2 * j)),
      .req_o       (pend[2*j])
    );
    assign pend[2*j+1] = tmr_ovf_i[j];
  end
  assign pend[N_SRC-1] = ser_flag_i;

  irq_arbiter #(.N_SRC(N_SRC)) u_arb (
    .pend_i   (pend),
    .en_i     (src_en_i),
    .gie_i    (glb_en_i),
    .prio_i   (prio_i),
    .in_svc_i (in_svc_o),
    .valid_o  (win_valid),
    .src_o    (win_src),
    .lvl_o    (win_lvl)
  );

  irq_svc_track u_svc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take),
    .take_lvl_i (lvl_q),
    .reti_i     (reti_i),
    .in_svc_o   (in_svc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      src_q <= '0;
      lvl_q <= LVL_LO;
    end else begin
      // acknowledge blanks one cycle so in-service is seen before re-arbitration
      irq_q <= win_valid & ~ack_i;
      src_q <= win_src;
      lvl_q <= win_lvl;
    end
  end

  assign irq_o     = irq_q;
  assign irq_lvl_o = irq_q & (lvl_q == LVL_HI);
  assign vector_o  = irq_q ? VEC_W'(VEC_BASE) + VEC_W'(src_q) * VEC_W'(VEC_STRIDE)
                           : '0;
endmodule

// File: rtl/irq_ctrl_2lvl_chk.sv
module irq_ctrl_2lvl_chk #(
  parameter int VEC_W      = 8,
  parameter int N_SRC      = 5,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             glb_en_i,
  input logic             ack_i,
  input logic             reti_i,
  input logic             irq_o,
  input logic             irq_lvl_o,
  input logic [VEC_W-1:0] vector_o,
  input logic [1:0]       in_svc_o
);
  assert_idle_vec_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> vector_o == '0);

  assert_gie_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en_i |=> !irq_o);

  assert_vec_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (int'(vector_o) >= VEC_BASE) &&
              (int'(vector_o) <= VEC_BASE + (N_SRC - 1) * VEC_STRIDE));

  assert_ack_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && irq_o |=> !irq_o);

  assert_high_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_svc_o[1] |-> !irq_o);

  assert_low_nest_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && in_svc_o[0] |-> irq_lvl_o);

  assert_reti_hi_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reti_i && !ack_i && in_svc_o[1] |=> !in_svc_o[1] && in_svc_o[0] == $past(in_svc_o[0]));
endmodule

bind irq_ctrl_2lvl irq_ctrl_2lvl_chk #(
  .VEC_W(VEC_W), .N_SRC(N_SRC), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .glb_en_i  (glb_en_i),
  .ack_i     (ack_i),
  .reti_i    (reti_i),
  .irq_o     (irq_o),
  .irq_lvl_o (irq_lvl_o),
  .vector_o  (vector_o),
  .in_svc_o  (in_svc_o)
);

// File: tb/irq_ctrl_2lvl_tb.sv
module irq_ctrl_2lvl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 11;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic [1:0] ext_ni, ext_edge, tmr_ovf;
  logic       ser_flag, glb_en, ack, reti;
  logic [4:0] src_en, prio;
  logic       irq, irq_lvl;
  logic [7:0] vector;
  logic [1:0] in_svc;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_ctrl_2lvl u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .ext_ni     (ext_ni),
    .ext_edge_i (ext_edge),
    .tmr_ovf_i  (tmr_ovf),
    .ser_flag_i (ser_flag),
    .glb_en_i   (glb_en),
    .src_en_i   (src_en),
    .prio_i     (prio),
    .ack_i      (ack),
    .reti_i     (reti),
    .irq_o      (irq),
    .vector_o   (vector),
    .irq_lvl_o  (irq_lvl),
    .in_svc_o   (in_svc)
  );

  // {glb, en[4:0], prio[4:0], ext_n[1:0], tmr[1:0], ser, exp_irq, exp_vec[7:0], exp_lvl}
  localparam logic [25:0] TBL [N_VEC] = '{
    {1'b0, 5'h1F, 5'h00, 2'b00, 2'b11, 1'b1, 1'b0, 8'h00, 1'b0},
    {1'b1, 5'h00, 5'h00, 2'b00, 2'b11, 1'b1, 1'b0, 8'h00, 1'b0},
    {1'b1, 5'h1F, 5'h00, 2'b00, 2'b11, 1'b1, 1'b1, 8'h03, 1'b0},
    {1'b1, 5'h1F, 5'h10, 2'b00, 2'b11, 1'b1, 1'b1, 8'h23, 1'b1},
    {1'b1, 5'h1F, 5'h0A, 2'b00, 2'b11, 1'b1, 1'b1, 8'h0B, 1'b1},
    {1'b1, 5'h1E, 5'h00, 2'b00, 2'b11, 1'b1, 1'b1, 8'h0B, 1'b0},
    {1'b1, 5'h04, 5'h00, 2'b01, 2'b00, 1'b0, 1'b1, 8'h13, 1'b0},
    {1'b1, 5'h08, 5'h00, 2'b11, 2'b10, 1'b0, 1'b1, 8'h1B, 1'b0},
    {1'b1, 5'h1F, 5'h00, 2'b11, 2'b00, 1'b1, 1'b1, 8'h23, 1'b0},
    {1'b1, 5'h1F, 5'h1F, 2'b11, 2'b00, 1'b0, 1'b0, 8'h00, 1'b0},
    {1'b1, 5'h1F, 5'h04, 2'b00, 2'b01, 1'b0, 1'b1, 8'h13, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    ext_ni = 2'b11; ext_edge = 2'b00; tmr_ovf = 2'b00; ser_flag = 1'b0;
    glb_en = 1'b0; src_en = '0; prio = '0; ack = 1'b0; reti = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    step();
    ack = 1'b0;
  endtask

  task automatic pulse_reti();
    reti = 1'b1;
    step();
    reti = 1'b0;
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 irq", int'(irq), 0);
    chk("R1 vector", int'(vector), 0);
    chk("R1 in_svc", int'(in_svc), 0);

    // table walk: R2 R3 R4 R5 R6 R11, level mode, nothing in service
    for (int k = 0; k < N_VEC; k++) begin
      glb_en = TBL[k][25]; src_en = TBL[k][24:20]; prio = TBL[k][19:15];
      ext_ni = TBL[k][14:13]; tmr_ovf = TBL[k][12:11]; ser_flag = TBL[k][10];
      step();
      chk($sformatf("R2/R4/R5 row %0d irq", k), int'(irq), int'(TBL[k][9]));
      chk($sformatf("R3 row %0d vector", k), int'(vector), int'(TBL[k][8:1]));
      chk($sformatf("R11 row %0d level", k), int'(irq_lvl), int'(TBL[k][0]));
    end

    // R7 edge mode on ext0: latch, hold, clear on ack
    do_reset();
    glb_en = 1'b1; src_en = 5'h01; ext_edge = 2'b01;
    ext_ni[0] = 1'b0;
    step();
    chk("R7 first edge no irq", int'(irq), 0);
    ext_ni[0] = 1'b1;
    step();
    chk("R7 latched irq", int'(irq), 1);
    chk("R7 latched vector", int'(vector), 8'h03);
    pulse_ack();
    chk("R8 irq after ack", int'(irq), 0);
    chk("R8 low in service", int'(in_svc), 2'b01);
    pulse_reti();
    chk("R10 low cleared", int'(in_svc), 2'b00);
    step();
    chk("R7 flag cleared by ack", int'(irq), 0);

    // R7 level request not cleared by ack
    do_reset();
    glb_en = 1'b1; src_en = 5'h01; ext_ni[0] = 1'b0;
    step();
    chk("R6 level irq", int'(irq), 1);
    pulse_ack();
    chk("R8 ack level", int'(in_svc), 2'b01);
    pulse_reti();
    step();
    chk("R7 level persists", int'(irq), 1);

    // R9 nesting, R10 return order
    do_reset();
    glb_en = 1'b1; src_en = 5'h1F; prio = 5'h02; tmr_ovf = 2'b10;
    step();
    chk("R5 tmr1 low vec", int'(vector), 8'h1B);
    pulse_ack();
    chk("R8 low taken", int'(in_svc), 2'b01);
    ext_ni[0] = 1'b0;
    step();
    chk("R9 low blocked by low", int'(irq), 0);
    tmr_ovf[0] = 1'b1;
    step();
    chk("R9 high preempts", int'(vector), 8'h0B);
    chk("R11 high level", int'(irq_lvl), 1);
    pulse_ack();
    tmr_ovf[0] = 1'b0;
    chk("R8 high taken", int'(in_svc), 2'b11);
    step();
    chk("R9 nothing over high", int'(irq), 0);
    pulse_reti();
    chk("R10 high cleared first", int'(in_svc), 2'b01);
    step();
    chk("R9 still low service", int'(irq), 0);
    pulse_reti();
    chk("R10 low cleared", int'(in_svc), 2'b00);
    step();
    chk("R10 resume ext0", int'(vector), 8'h03);

    // R2 masked edge stays pending
    do_reset();
    glb_en = 1'b1; src_en = 5'h00; ext_edge = 2'b10;
    ext_ni[1] = 1'b0;
    step();
    ext_ni[1] = 1'b1;
    step();
    chk("R2 masked no irq", int'(irq), 0);
    src_en = 5'h04;
    step();
    chk("R2 pending presented", int'(vector), 8'h13);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule